// File: doc/BRIEF.md
# SD card command state machine

This block is the command core of a memory card model that is strapped into either native bus mode or SPI mode. A decoded command arrives as a 6-bit index with an application-command flag and a one-cycle valid strobe. One cycle later the block returns a response-type code with a valid pulse. It keeps the card state, and it shows that state and an illegal-command flag in a 32-bit status word.

The mode strap changes the command set. In native mode the card walks the usual identification sequence: idle, ready, identification, standby, then transfer. In SPI mode a single initialisation command moves the card straight to transfer, and commands that only exist on the native bus are refused. In SPI mode the two 16-byte identity registers (card-specific data and card identification) are not returned as long responses. They are streamed as data through a byte-wide read port. The chip select is not modelled, so the surrounding logic must deliver commands only while the card is selected.

Top module: `sdcard_cmd_core`

## Requirements
- R1: After reset the status word is 0 (state idle = 0, illegal flag clear), rsp_valid is 0, rsp_type is 0, data_ready is 0 and rd_data is 0.
- R2: The mode input is captured on the first clock edge after reset is released (1 = SPI, 0 = native). Later changes of spi_mode have no effect until the next reset.
- R3: For each cmd_valid cycle, rsp_valid is high for exactly the next cycle, and rsp_type holds the response code (0 none, 1 short status, 2 long register, 3 operating conditions) until the next command. Status bits 12:9 carry the state (idle 0, ready 1, identification 2, standby 3, transfer 4, sending-data 5), and bit 22 is the illegal-command flag.
- R4: Command 0 (app flag clear) moves the card to idle from any state. It answers code 1 in SPI mode and code 0 in native mode.
- R5: In SPI mode, command 1 (app flag clear) and application command 41 move the card to transfer from any state and answer code 1.
- R6: A command that is not accepted sets status bit 22, answers code 0 and leaves the state unchanged. In SPI mode this covers commands 2, 3, 4, 6, 7, 11, 15, 24, 25, 26, 27 and 42. In native mode it covers command 1.
- R7: An accepted command clears status bit 22.
- R8: In native mode, the following transitions apply, and any other command or state is refused as in R6.
  - Application command 41: idle to ready, code 3.
  - Command 2: ready to identification, code 2.
  - Command 3: identification or standby to standby, code 1.
  - Command 7: standby to transfer, code 1.
  - Command 9 or 10 in standby: code 2, the state stays standby and data_ready stays low.
- R9: In SPI mode, command 9 or 10 in the transfer state enters sending-data, answers code 1 and raises data_ready. The same commands in any other state are refused.
- R10: In sending-data, each rd_strobe puts the next byte on rd_data in the following cycle. Bytes come most significant first, from the card-specific register after command 9 and from the identification register after command 10. The 16th byte returns the card to transfer, and data_ready falls.
- R11: rd_strobe outside sending-data is ignored: rd_data, the state and the status word stay unchanged.
- R12: When a command and rd_strobe fall in the same cycle, the read is served against the state before the edge. An accepted command then sets the next state. A refused command leaves the state to the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_mode | input | 1 | Mode strap, captured after reset (1 = SPI) |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_index | input | 6 | Command index |
| cmd_app | input | 1 | Application-command flag |
| rsp_valid | output | 1 | Response pulse, one cycle after cmd_valid |
| rsp_type | output | 2 | Response code of the last command |
| card_status | output | 32 | Status word: state in 12:9, illegal flag in 22 |
| data_ready | output | 1 | High while register bytes are being streamed |
| rd_strobe | input | 1 | Read request for the next register byte |
| rd_data | output | 8 | Last register byte read |

## Verification
A command and a register read can land in the same cycle. This happens when the host sends a command while a register stream is still running. The bench provokes it on purpose in three ways:
- a refused command in the middle of a stream, where the read must advance and the stream must continue;
- an accepted command in the middle of a stream, where the byte is still delivered but the state follows the command;
- random mixes of both strobes.

Each outcome is judged against a bench model that serves the read from the state before the edge and applies the command's state only when it is accepted.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_READY = 4'd1,
      ST_IDENT = 4'd2,
      ST_STBY  = 4'd3,
      ST_TRAN  = 4'd4,
      ST_DATA  = 4'd5
   } card_state_t;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_R1   = 2'd1,
      RSP_R2   = 2'd2,
      RSP_R3   = 2'd3
   } rsp_kind_t;
endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
   import sdc_pkg::*;
(
   input  card_state_t state,
   input  logic        spi,
   input  logic [5:0]  idx,
   input  logic        app,
   output card_state_t nxt,
   output rsp_kind_t   rsp,
   output logic        illegal,
   output logic        load,
   output logic        sel_cid
);
   logic is_reg_cmd;
   assign is_reg_cmd = !app && (idx == 6'd9 || idx == 6'd10);

   always_comb begin
      nxt     = state;
      rsp     = RSP_NONE;
      illegal = 1'b0;
      load    = 1'b0;
      sel_cid = (idx == 6'd10);
      if (!app && idx == 6'd0) begin
         nxt = ST_IDLE;
         rsp = spi ? RSP_R1 : RSP_NONE;
      end else if (spi) begin
         if ((!app && idx == 6'd1) || (app && idx == 6'd41)) begin
            nxt = ST_TRAN;
            rsp = RSP_R1;
         end else if (is_reg_cmd && state == ST_TRAN) begin
            nxt  = ST_DATA;
            rsp  = RSP_R1;
            load = 1'b1;
         end else begin
            illegal = 1'b1;
         end
      end else begin
         if (app && idx == 6'd41 && state == ST_IDLE) begin
            nxt = ST_READY;
            rsp = RSP_R3;
         end else if (!app && idx == 6'd2 && state == ST_READY) begin
            nxt = ST_IDENT;
            rsp = RSP_R2;
         end else if (!app && idx == 6'd3 && (state == ST_IDENT || state == ST_STBY)) begin
            nxt = ST_STBY;
            rsp = RSP_R1;
         end else if (!app && idx == 6'd7 && state == ST_STBY) begin
            nxt = ST_TRAN;
            rsp = RSP_R1;
         end else if (is_reg_cmd && state == ST_STBY) begin
            rsp = RSP_R2;
         end else begin
            illegal = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdc_reg_reader.sv
module sdc_reg_reader #(
   parameter int                        REG_BYTES = 16,
   parameter logic [8*REG_BYTES-1:0]    CSD_VALUE = '0,
   parameter logic [8*REG_BYTES-1:0]    CID_VALUE = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       load_cid,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       last
);
   localparam int OFF_W = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(REG_BYTES - 1);

   logic [7:0]       csd_b [REG_BYTES];
   logic [7:0]       cid_b [REG_BYTES];
   logic [OFF_W-1:0] off_q;
   logic             sel_q;

   for (genvar g = 0; g < REG_BYTES; g++) begin : g_slice
      assign csd_b[g] = CSD_VALUE[8*(REG_BYTES-1-g) +: 8];
      assign cid_b[g] = CID_VALUE[8*(REG_BYTES-1-g) +: 8];
   end

   assign last = (off_q == OFF_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         sel_q   <= 1'b0;
         rd_data <= 8'h00;
      end else begin
         if (rd_en) begin
            rd_data <= sel_q ? cid_b[off_q] : csd_b[off_q];
            off_q   <= last ? '0 : off_q + 1'b1;
         end
         if (load) begin
            off_q <= '0;
            sel_q <= load_cid;
         end
      end
   end
endmodule

// File: rtl/sdcard_cmd_core.sv
module sdcard_cmd_core
   import sdc_pkg::*;
#(
   parameter int                        REG_BYTES   = 16,
   parameter int                        STATE_LSB   = 9,
   parameter int                        ILLEGAL_BIT = 22,
   parameter logic [8*REG_BYTES-1:0]    CSD_VALUE   = {8*REG_BYTES{1'b0}} | 128'h0026_0032_5F59_83C8_BEFB_CFFF_9280_40DF,
   parameter logic [8*REG_BYTES-1:0]    CID_VALUE   = {8*REG_BYTES{1'b0}} | 128'h1B53_4D53_4430_3110_0000_0001_0078_1201
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_mode,
   input  logic        cmd_valid,
   input  logic [5:0]  cmd_index,
   input  logic        cmd_app,
   output logic        rsp_valid,
   output logic [1:0]  rsp_type,
   output logic [31:0] card_status,
   output logic        data_ready,
   input  logic        rd_strobe,
   output logic [7:0]  rd_data
);
   localparam int STATE_W = 4;

   if (REG_BYTES < 2) begin : g_bad_bytes
      $error("REG_BYTES must be at least 2");
   end
   if (STATE_LSB < 0 || STATE_LSB + STATE_W > 32) begin : g_bad_field
      $error("state field must lie inside the status word");
   end
   if (ILLEGAL_BIT < 0 || ILLEGAL_BIT > 31 ||
       (ILLEGAL_BIT >= STATE_LSB && ILLEGAL_BIT < STATE_LSB + STATE_W)) begin : g_bad_ill
      $error("illegal flag must lie outside the state field");
   end

   card_state_t state_q, dec_nxt;
   rsp_kind_t   dec_rsp;
   logic        spi_q, cap_pend_q, ill_q;
   logic        dec_ill, dec_load, dec_cid;
   logic        rd_fire, rd_last;

   sdc_cmd_decode u_decode (
      .state   (state_q),
      .spi     (spi_q),
      .idx     (cmd_index),
      .app     (cmd_app),
      .nxt     (dec_nxt),
      .rsp     (dec_rsp),
      .illegal (dec_ill),
      .load    (dec_load),
      .sel_cid (dec_cid)
   );

   assign rd_fire = rd_strobe && (state_q == ST_DATA);

   sdc_reg_reader #(
      .REG_BYTES (REG_BYTES),
      .CSD_VALUE (CSD_VALUE),
      .CID_VALUE (CID_VALUE)
   ) u_reader (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cmd_valid && dec_load),
      .load_cid (dec_cid),
      .rd_en    (rd_fire),
      .rd_data  (rd_data),
      .last     (rd_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_pend_q <= 1'b1;
         spi_q      <= 1'b0;
      end else if (cap_pend_q) begin
         cap_pend_q <= 1'b0;
         spi_q      <= spi_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ill_q     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_type  <= RSP_NONE;
      end else begin
         rsp_valid <= cmd_valid;
         if (cmd_valid) begin
            rsp_type <= dec_rsp;
            ill_q    <= dec_ill;
         end
         if (cmd_valid && !dec_ill) state_q <= dec_nxt;
         else if (rd_fire && rd_last) state_q <= ST_TRAN;
      end
   end

   always_comb begin
      card_status = '0;
      card_status[STATE_LSB +: STATE_W] = state_q;
      card_status[ILLEGAL_BIT] = ill_q;
   end

   assign data_ready = (state_q == ST_DATA);
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       spi,
   input logic       cmd_valid,
   input logic       rd_strobe,
   input logic       rsp_valid,
   input logic [1:0] rsp_type,
   input logic       ill,
   input logic       data_ready
);
   p_rsp_follows_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_valid));

   p_refused_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && ill) |-> (rsp_type == 2'd0));

   p_native_no_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !spi |-> !data_ready);

   p_stream_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> (rsp_valid && rsp_type == 2'd1));

   p_stream_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> ($past(cmd_valid) || $past(rd_strobe)));
endmodule

bind sdcard_cmd_core sdc_checker u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi        (spi_q),
   .cmd_valid  (cmd_valid),
   .rd_strobe  (rd_strobe),
   .rsp_valid  (rsp_valid),
   .rsp_type   (rsp_type),
   .ill        (card_status[ILLEGAL_BIT]),
   .data_ready (data_ready)
);

// File: tb/test_sdcard_cmd_core.sv
module test_sdcard_cmd_core;
   localparam logic [127:0] BCSD = 128'h00_11_22_33_44_55_66_77_88_99_AA_BB_CC_DD_EE_F1;
   localparam logic [127:0] BCID = 128'hF0_E1_D2_C3_B4_A5_96_87_78_69_5A_4B_3C_2D_1E_0F;

   logic clk = 1'b0, rst_n = 1'b0, spi_mode = 1'b0;
   logic cmd_valid = 1'b0, cmd_app = 1'b0, rd_strobe = 1'b0;
   logic [5:0] cmd_index = '0;
   logic rsp_valid, data_ready;
   logic [1:0] rsp_type;
   logic [31:0] card_status;
   logic [7:0] rd_data;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [3:0] m_state;
   logic       m_ill, m_spi, m_sel;
   logic [1:0] m_rsp;
   int         m_off;
   logic [7:0] m_rd;

   always #5 clk = ~clk;

   sdcard_cmd_core #(.CSD_VALUE(BCSD), .CID_VALUE(BCID)) i_sdcard_cmd_core (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cmd_valid(cmd_valid),
      .cmd_index(cmd_index), .cmd_app(cmd_app), .rsp_valid(rsp_valid),
      .rsp_type(rsp_type), .card_status(card_status), .data_ready(data_ready),
      .rd_strobe(rd_strobe), .rd_data(rd_data));

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_byte(input logic cid, input int k);
      logic [127:0] v;
      v = cid ? BCID : BCSD;
      return 8'((v >> (8 * (15 - k))) & 128'hFF);
   endfunction

   function automatic logic [31:0] exp_status();
      logic [31:0] s;
      s = '0;
      s[12:9] = m_state;
      s[22] = m_ill;
      return s;
   endfunction

   task automatic do_reset(input logic mode);
      cmd_valid = 0; rd_strobe = 0; cmd_app = 0; cmd_index = 0;
      spi_mode = mode;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      m_state = 0; m_ill = 0; m_spi = mode; m_sel = 0; m_rsp = 0; m_off = 0; m_rd = 0;
   endtask

   // Model of one command / read cycle, written from the requirements.
   task automatic model(input logic v, input logic [5:0] idx, input logic app, input logic rd);
      logic [3:0] cn, rn;
      logic [1:0] rt;
      logic il, ld;
      rn = m_state;
      if (rd && m_state == 4'd5) begin
         m_rd = reg_byte(m_sel, m_off);
         if (m_off == 15) begin rn = 4'd4; m_off = 0; end
         else m_off++;
      end
      if (v) begin
         cn = m_state; rt = 0; il = 0; ld = 0;
         if (!app && idx == 0) begin cn = 0; rt = m_spi ? 2'd1 : 2'd0; end
         else if (m_spi) begin
            if ((!app && idx == 1) || (app && idx == 41)) begin cn = 4; rt = 1; end
            else if (!app && (idx == 9 || idx == 10) && m_state == 4) begin cn = 5; rt = 1; ld = 1; end
            else il = 1;
         end else begin
            if (app && idx == 41 && m_state == 0) begin cn = 1; rt = 3; end
            else if (!app && idx == 2 && m_state == 1) begin cn = 2; rt = 2; end
            else if (!app && idx == 3 && (m_state == 2 || m_state == 3)) begin cn = 3; rt = 1; end
            else if (!app && idx == 7 && m_state == 3) begin cn = 4; rt = 1; end
            else if (!app && (idx == 9 || idx == 10) && m_state == 3) begin cn = 3; rt = 2; end
            else il = 1;
         end
         m_rsp = rt; m_ill = il;
         if (ld) begin m_off = 0; m_sel = (idx == 10); end
         m_state = il ? rn : cn;
      end else begin
         m_state = rn;
      end
   endtask

   task automatic cyc(input string tag, input logic v, input logic [5:0] idx, input logic app, input logic rd);
      cmd_valid = v; cmd_index = idx; cmd_app = app; rd_strobe = rd;
      @(posedge clk);
      model(v, idx, app, rd);
      @(negedge clk);
      cmd_valid = 0; rd_strobe = 0; cmd_app = 0;
      check(tag, "rsp_valid", 32'(rsp_valid), 32'(v));
      check(tag, "rsp_type", 32'(rsp_type), 32'(m_rsp));
      check(tag, "status", card_status, exp_status());
      check(tag, "data_ready", 32'(data_ready), 32'(m_state == 4'd5));
      check(tag, "rd_data", 32'(rd_data), 32'(m_rd));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20071124));
      // R1: reset state
      do_reset(1'b0);
      check("R1", "status", card_status, 32'h0);
      check("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
      check("R1", "rsp_type", 32'(rsp_type), 32'h0);
      check("R1", "data_ready", 32'(data_ready), 32'h0);
      check("R1", "rd_data", 32'(rd_data), 32'h0);

      // Native identification sequence
      cyc("R6", 1, 6'd1, 0, 0);
      cyc("R8", 1, 6'd9, 0, 0);
      cyc("R7", 1, 6'd41, 1, 0);
      cyc("R8", 1, 6'd2, 0, 0);
      cyc("R8", 1, 6'd3, 0, 0);
      cyc("R8", 1, 6'd10, 0, 1);
      cyc("R8", 1, 6'd7, 0, 0);
      cyc("R4", 1, 6'd0, 0, 0);
      check("R4", "native cmd0 code", 32'(rsp_type), 32'h0);

      // SPI mode
      do_reset(1'b1);
      cyc("R9", 1, 6'd9, 0, 0);
      cyc("R5", 1, 6'd41, 1, 0);
      cyc("R4", 1, 6'd0, 0, 0);
      check("R4", "spi cmd0 code", 32'(rsp_type), 32'h1);
      spi_mode = 1'b0;
      cyc("R2", 1, 6'd1, 0, 0);
      check("R2", "strap held", card_status, 32'h0000_0800);
      cyc("R11", 0, 6'd0, 0, 1);
      cyc("R6", 1, 6'd2, 0, 0);
      cyc("R6", 1, 6'd24, 0, 0);
      cyc("R6", 1, 6'd42, 0, 0);
      cyc("R9", 1, 6'd9, 0, 0);
      for (int k = 0; k < 16; k++) cyc("R10", 0, 6'd0, 0, 1);
      check("R10", "csd last byte", 32'(rd_data), 32'hF1);
      cyc("R9", 1, 6'd10, 0, 0);
      for (int k = 0; k < 4; k++) cyc("R10", 0, 6'd0, 0, 1);
      cyc("R12", 1, 6'd7, 0, 1);
      for (int k = 0; k < 10; k++) cyc("R10", 0, 6'd0, 0, 1);
      cyc("R12", 1, 6'd15, 0, 1);
      check("R12", "end on refused cmd", 32'(data_ready), 32'h0);
      cyc("R9", 1, 6'd10, 0, 0);
      cyc("R12", 1, 6'd1, 0, 1);
      check("R12", "byte served", 32'(rd_data), 32'hF0);
      cyc("R9", 1, 6'd9, 0, 0);
      cyc("R12", 1, 6'd0, 0, 1);

      // Random mix, both modes
      for (int r = 0; r < 8; r++) begin
         do_reset(1'(r % 2));
         for (int n = 0; n < 1500; n++) begin
            logic [5:0] pool [12];
            logic [5:0] ix;
            logic a;
            pool = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd7, 6'd9, 6'd10, 6'd13, 6'd24, 6'd41, 6'd42, 6'd55};
            ix = pool[$urandom_range(11, 1) - ((($urandom % 16) == 0) ? 1 : 0)];
            a = (ix == 6'd41) ? (($urandom % 4) != 0) : (($urandom % 8) == 0);
            cyc("R3", ($urandom % 3) == 0, ix, a, ($urandom % 2) == 0);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule